// File: doc/BRIEF.md
# ADC Conversion Start and Tracking Sequencer

This block is the digital control sequencer for a successive-approximation converter. A two-bit source field chooses which event launches a conversion group. The choices are a software strobe, a synchronized rising edge on an external pin, a Timer1 overflow, or a Timer2 overflow. For Timer2, the low-byte or high-byte overflow is used depending on how that timer is split. Before each conversion the sequencer applies the selected tracking policy. It then asks an external converter core for a sample through a request/done handshake.

A group holds 1, 4, 8 or 16 conversions, and their results are summed. The busy output covers the whole group. When busy falls, an end-of-conversion flag is set. The flag drives an interrupt line when that interrupt is enabled, and software clears the flag with a strobe. The summed result is presented either right-justified or left-justified in the output word.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The start source is selected by `cfg_start_mode`: 00 selects `sw_start`, 01 selects a synchronized rising edge of `cnv_pin`, 10 selects `t1_ovf`, and 11 selects Timer2. Events from sources that are not selected never start a group.
- R2: With Timer2 selected, `t2_lo_ovf` starts a group when `cfg_t2_split` is 1 and `t2_hi_ovf` starts a group when it is 0. The other Timer2 overflow is ignored.
- R3: `busy` rises in the cycle after the start event is sampled and stays high until the last conversion of the group is done. `conv_req` is high only while `busy` is high. Start events that arrive while busy is high are ignored.
- R4: `eoc_flag` is set at the same clock edge at which `busy` falls, and at no other edge.
- R5: `irq` is high exactly when `eoc_flag` is 1 and `cfg_eoc_ie` is 1.
- R6: A pulse on `eoc_clr` clears `eoc_flag`. If a clear and a completion fall in the same cycle, the flag ends up at 1.
- R7: Pre-tracking (`cfg_track_mode`=10 with `cfg_burst`=0) asserts `conv_req` in the first busy cycle, and `track_en` is high whenever the block is idle.
- R8: Post-tracking (`cfg_track_mode`=00 or 01, or 10 with `cfg_burst`=1) holds `track_en` low while idle. It tracks for `cfg_track_time`+1 busy cycles before `conv_req` rises.
- R9: Dual-tracking (`cfg_track_mode`=11) holds `track_en` high while idle and also applies the timed interval of R8 after the start.
- R10: `cfg_repeat` codes 00/01/10/11 give 1/4/8/16 conversions per group. The result is the sum of the converter words of the group.
- R11: With `cfg_left_just`=0 the sum sits in the low bits of `data_out`, zero-extended. With 1, it is shifted left by OUT_W-RES_W-4 bits, which is 2 at the defaults.
- R12: After reset, `busy`, `conv_req`, `eoc_flag`, `irq` and `data_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_start_mode | input | 2 | Start source select |
| cfg_t2_split | input | 1 | Timer2 in 8-bit mode (use low-byte overflow) |
| cfg_track_mode | input | 2 | Tracking policy |
| cfg_burst | input | 1 | Burst operation (forces post-tracking instead of pre) |
| cfg_track_time | input | TK_W | Post-start tracking length minus one |
| cfg_repeat | input | 2 | Conversions per group code |
| cfg_left_just | input | 1 | Left-justify output word |
| cfg_eoc_ie | input | 1 | End-of-conversion interrupt enable |
| sw_start | input | 1 | Software start strobe |
| eoc_clr | input | 1 | Software clear of the end flag |
| cnv_pin | input | 1 | Asynchronous external start pin |
| t1_ovf | input | 1 | Timer1 overflow pulse |
| t2_lo_ovf | input | 1 | Timer2 low-byte overflow pulse |
| t2_hi_ovf | input | 1 | Timer2 high-byte overflow pulse |
| conv_req | output | 1 | Request to converter core |
| conv_done | input | 1 | Converter result valid pulse |
| conv_data | input | RES_W | Converter result word |
| track_en | output | 1 | Converter input tracking enable |
| busy | output | 1 | Group in progress |
| eoc_flag | output | 1 | End-of-conversion flag |
| irq | output | 1 | Gated interrupt |
| data_out | output | OUT_W | Formatted accumulated result |

## Verification
The bound assertions check several rules on every cycle. A request is never made outside busy. The flag only rises where busy falls, and busy always falls into a set flag. The interrupt never appears without the flag. The first busy cycle either carries a request (pre-tracking) or does not (the timed policies). Other behaviours only the bench scenarios can show. These are the exact tracking length, the number of conversions and their sum, the justification, and the Timer2 byte selection. The same goes for rejection of unselected or mid-group starts and the clear-versus-completion collision.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int REP_LOG = 4;

    typedef enum logic [1:0] {
        SRC_SW   = 2'b00,
        SRC_PIN  = 2'b01,
        SRC_TMR1 = 2'b10,
        SRC_TMR2 = 2'b11
    } start_src_e;

    typedef enum logic [1:0] {
        TRK_POST0 = 2'b00,
        TRK_POST  = 2'b01,
        TRK_PRE   = 2'b10,
        TRK_DUAL  = 2'b11
    } trk_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_TRACK = 2'b01,
        ST_CONV  = 2'b10
    } seq_state_e;

    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } pin_sync_t;

    function automatic logic [REP_LOG-1:0] last_index(input logic [1:0] code);
        case (code)
            2'b00:   last_index = 4'd0;
            2'b01:   last_index = 4'd3;
            2'b10:   last_index = 4'd7;
            default: last_index = 4'd15;
        endcase
    endfunction

endpackage

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
    import adc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] start_mode,
    input  logic       t2_split,
    input  logic       sw_start,
    input  logic       cnv_pin,
    input  logic       t1_ovf,
    input  logic       t2_lo_ovf,
    input  logic       t2_hi_ovf,
    output logic       trig
);
    pin_sync_t sync_d, sync_q;
    logic      pin_rise;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = cnv_pin;
        sync_d.s2 = sync_q.s1;
        sync_d.s3 = sync_q.s2;
        pin_rise  = sync_q.s2 & ~sync_q.s3;
        case (start_src_e'(start_mode))
            SRC_SW:   trig = sw_start;
            SRC_PIN:  trig = pin_rise;
            SRC_TMR1: trig = t1_ovf;
            default:  trig = t2_split ? t2_lo_ovf : t2_hi_ovf;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end
endmodule

// File: rtl/adc_track_policy.sv
module adc_track_policy
    import adc_seq_pkg::*;
(
    input  logic [1:0] track_mode,
    input  logic       burst,
    input  logic       idle,
    input  logic       in_track,
    output logic       pre_eff,
    output logic       track_en
);
    logic dual;

    always_comb begin
        pre_eff  = (trk_mode_e'(track_mode) == TRK_PRE) && !burst;
        dual     = (trk_mode_e'(track_mode) == TRK_DUAL);
        track_en = in_track | (idle & (pre_eff | dual));
    end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int RES_W = 10,
    parameter int TK_W  = 4,
    localparam int ACC_W = RES_W + REP_LOG
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic             pre_eff,
    input  logic [TK_W-1:0]  track_time,
    input  logic [1:0]       repeat_code,
    input  logic             eoc_clr,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_data,
    output logic             busy,
    output logic             idle,
    output logic             in_track,
    output logic             conv_req,
    output logic             eoc_flag,
    output logic [ACC_W-1:0] result
);
    typedef struct packed {
        seq_state_e         st;
        logic [TK_W-1:0]    trk;
        logic [REP_LOG-1:0] rep;
        logic [ACC_W-1:0]   acc;
        logic [ACC_W-1:0]   res;
        logic               eoc;
    } fsm_t;

    fsm_t             s_d, s_q;
    logic             eoc_set;
    logic [ACC_W-1:0] acc_sum;

    always_comb begin
        s_d     = s_q;
        eoc_set = 1'b0;
        acc_sum = s_q.acc + ACC_W'(conv_data);
        case (s_q.st)
            ST_IDLE: begin
                if (trig) begin
                    s_d.acc = '0;
                    s_d.rep = '0;
                    s_d.trk = track_time;
                    s_d.st  = pre_eff ? ST_CONV : ST_TRACK;
                end
            end
            ST_TRACK: begin
                if (s_q.trk == '0) s_d.st  = ST_CONV;
                else               s_d.trk = s_q.trk - TK_W'(1);
            end
            ST_CONV: begin
                if (conv_done) begin
                    if (s_q.rep == last_index(repeat_code)) begin
                        s_d.st  = ST_IDLE;
                        s_d.res = acc_sum;
                        eoc_set = 1'b1;
                    end else begin
                        s_d.rep = s_q.rep + REP_LOG'(1);
                        s_d.acc = acc_sum;
                        s_d.trk = track_time;
                        s_d.st  = pre_eff ? ST_CONV : ST_TRACK;
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
        if (eoc_set)      s_d.eoc = 1'b1;
        else if (eoc_clr) s_d.eoc = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign idle     = (s_q.st == ST_IDLE);
    assign busy     = !idle;
    assign in_track = (s_q.st == ST_TRACK);
    assign conv_req = (s_q.st == ST_CONV);
    assign eoc_flag = s_q.eoc;
    assign result   = s_q.res;
endmodule

// File: rtl/adc_result_fmt.sv
module adc_result_fmt #(
    parameter int ACC_W = 14,
    parameter int OUT_W = 16,
    localparam int SHIFT = OUT_W - ACC_W
) (
    input  logic [ACC_W-1:0] sum,
    input  logic             left_just,
    output logic [OUT_W-1:0] word
);
    logic [OUT_W-1:0] wide;

    always_comb begin
        wide = OUT_W'(sum);
        word = left_just ? (wide << SHIFT) : wide;
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int RES_W = 10,
    parameter int OUT_W = 16,
    parameter int TK_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_start_mode,
    input  logic             cfg_t2_split,
    input  logic [1:0]       cfg_track_mode,
    input  logic             cfg_burst,
    input  logic [TK_W-1:0]  cfg_track_time,
    input  logic [1:0]       cfg_repeat,
    input  logic             cfg_left_just,
    input  logic             cfg_eoc_ie,
    input  logic             sw_start,
    input  logic             eoc_clr,
    input  logic             cnv_pin,
    input  logic             t1_ovf,
    input  logic             t2_lo_ovf,
    input  logic             t2_hi_ovf,
    output logic             conv_req,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_data,
    output logic             track_en,
    output logic             busy,
    output logic             eoc_flag,
    output logic             irq,
    output logic [OUT_W-1:0] data_out
);
    localparam int ACC_W = RES_W + REP_LOG;

    logic             trig;
    logic             pre_eff;
    logic             idle;
    logic             in_track;
    logic [ACC_W-1:0] result;

    adc_trig_sel i_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_mode (cfg_start_mode),
        .t2_split   (cfg_t2_split),
        .sw_start   (sw_start),
        .cnv_pin    (cnv_pin),
        .t1_ovf     (t1_ovf),
        .t2_lo_ovf  (t2_lo_ovf),
        .t2_hi_ovf  (t2_hi_ovf),
        .trig       (trig)
    );

    adc_track_policy i_policy (
        .track_mode (cfg_track_mode),
        .burst      (cfg_burst),
        .idle       (idle),
        .in_track   (in_track),
        .pre_eff    (pre_eff),
        .track_en   (track_en)
    );

    adc_seq_fsm #(.RES_W(RES_W), .TK_W(TK_W)) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig        (trig),
        .pre_eff     (pre_eff),
        .track_time  (cfg_track_time),
        .repeat_code (cfg_repeat),
        .eoc_clr     (eoc_clr),
        .conv_done   (conv_done),
        .conv_data   (conv_data),
        .busy        (busy),
        .idle        (idle),
        .in_track    (in_track),
        .conv_req    (conv_req),
        .eoc_flag    (eoc_flag),
        .result      (result)
    );

    adc_result_fmt #(.ACC_W(ACC_W), .OUT_W(OUT_W)) i_fmt (
        .sum       (result),
        .left_just (cfg_left_just),
        .word      (data_out)
    );

    assign irq = eoc_flag & cfg_eoc_ie;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cfg_track_mode,
    input logic       cfg_burst,
    input logic       busy,
    input logic       conv_req,
    input logic       eoc_flag,
    input logic       irq
);
    logic pre_sel;
    assign pre_sel = (cfg_track_mode == 2'b10) && !cfg_burst;

    AST_REQ_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> busy); // R3
    AST_EOC_AT_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> eoc_flag); // R4
    AST_EOC_RISE_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eoc_flag) |-> $fell(busy)); // R4
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> eoc_flag); // R5
    AST_PRE_NO_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && pre_sel) |-> conv_req); // R7
    AST_TIMED_TRACK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && !pre_sel) |-> !conv_req); // R8
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk i_chk (.*);

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;
    localparam int RES_W = 10;
    localparam int OUT_W = 16;
    localparam int TK_W  = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       cfg_start_mode = '0;
    logic             cfg_t2_split = 1'b0;
    logic [1:0]       cfg_track_mode = '0;
    logic             cfg_burst = 1'b0;
    logic [TK_W-1:0]  cfg_track_time = '0;
    logic [1:0]       cfg_repeat = '0;
    logic             cfg_left_just = 1'b0;
    logic             cfg_eoc_ie = 1'b0;
    logic             sw_start = 1'b0;
    logic             clr_main = 1'b0;
    logic             clr_conv = 1'b0;
    logic             eoc_clr;
    logic             cnv_pin = 1'b0;
    logic             t1_ovf = 1'b0;
    logic             t2_lo_ovf = 1'b0;
    logic             t2_hi_ovf = 1'b0;
    logic             conv_req;
    logic             conv_done = 1'b0;
    logic [RES_W-1:0] conv_data = '0;
    logic             track_en, busy, eoc_flag, irq;
    logic [OUT_W-1:0] data_out;

    int nchk = 0;
    int nfail = 0;
    int n_done = 0;
    int sum = 0;
    int exp_rep = 1;
    int wt = 2;
    bit clr_on_last = 0;

    assign eoc_clr = clr_main | clr_conv;

    always #4 clk = ~clk;

    adc_seq_ctrl #(.RES_W(RES_W), .OUT_W(OUT_W), .TK_W(TK_W)) i_adc_seq_ctrl (.*);

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int rep_of(input logic [1:0] c);
        case (c)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 16;
        endcase
    endfunction

    function automatic int fmt(input int s, input bit left);
        return left ? ((s << (OUT_W - RES_W - 4)) & 16'hFFFF) : s;
    endfunction

    // converter core model
    initial begin
        forever begin
            @(negedge clk);
            conv_done = 1'b0;
            clr_conv  = 1'b0;
            if (rst_n && conv_req) begin
                if (wt == 0) begin
                    conv_data = RES_W'($urandom);
                    conv_done = 1'b1;
                    sum += int'(conv_data);
                    n_done++;
                    if (clr_on_last && n_done == exp_rep) clr_conv = 1'b1;
                    wt = 1 + int'($urandom % 4);
                end else begin
                    wt--;
                end
            end
        end
    end

    task automatic pulse_clear();
        clr_main = 1'b1;
        @(negedge clk);
        clr_main = 1'b0;
    endtask

    task automatic fire(input int src);
        case (src)
            0: sw_start = 1'b1;
            1: cnv_pin = 1'b1;
            2: t1_ovf = 1'b1;
            default: if (cfg_t2_split) t2_lo_ovf = 1'b1; else t2_hi_ovf = 1'b1;
        endcase
        @(negedge clk);
        sw_start = 1'b0; t1_ovf = 1'b0; t2_lo_ovf = 1'b0; t2_hi_ovf = 1'b0;
    endtask

    task automatic run_group(input int src, input logic [1:0] trk, input bit burst,
                             input int tt, input logic [1:0] rep, input bit left,
                             input bit ie, input bit split);
        int  cnt;
        bit  pre;
        cfg_start_mode = 2'(src); cfg_track_mode = trk; cfg_burst = burst;
        cfg_track_time = TK_W'(tt); cfg_repeat = rep; cfg_left_just = left;
        cfg_eoc_ie = ie; cfg_t2_split = split;
        pre = (trk == 2'b10) && !burst;
        n_done = 0; sum = 0; exp_rep = rep_of(rep);
        @(negedge clk);
        fire(src);
        for (int i = 0; i < 12 && !busy; i++) @(negedge clk);
        cnv_pin = 1'b0;
        chk("R1 start taken", int'(busy), 1);
        if (src != 1) begin
            sw_start = 1'b1; t1_ovf = 1'b1; t2_lo_ovf = 1'b1; t2_hi_ovf = 1'b1;
        end
        cnt = 0;
        while (!conv_req && cnt < 100) begin
            @(negedge clk);
            sw_start = 1'b0; t1_ovf = 1'b0; t2_lo_ovf = 1'b0; t2_hi_ovf = 1'b0;
            cnt++;
        end
        sw_start = 1'b0; t1_ovf = 1'b0; t2_lo_ovf = 1'b0; t2_hi_ovf = 1'b0;
        if (pre)               chk("R7 pre no tracking delay", cnt, 0);
        else if (trk == 2'b11) chk("R9 dual tracking length", cnt, tt + 1);
        else                   chk("R8 post tracking length", cnt, tt + 1);
        for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
        chk("R10 conversion count", n_done, exp_rep);
        chk("R4 flag set at end", int'(eoc_flag), 1);
        chk("R5 irq gating", int'(irq), int'(ie));
        chk("R11 result word", int'(data_out), fmt(sum, left));
        repeat (4) @(negedge clk);
        chk("R3 mid-group start ignored", int'(busy), 0);
        if (pre || trk == 2'b11) chk("R7 R9 idle tracking on", int'(track_en), 1);
        else                     chk("R8 idle tracking off", int'(track_en), 0);
        pulse_clear();
        chk("R6 flag cleared", int'(eoc_flag), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 busy", int'(busy), 0);
        chk("R12 conv_req", int'(conv_req), 0);
        chk("R12 eoc_flag", int'(eoc_flag), 0);
        chk("R12 irq", int'(irq), 0);
        chk("R12 data_out", int'(data_out), 0);
        chk("R8 idle post tracking off", int'(track_en), 0);

        run_group(0, 2'b01, 0, 3, 2'b00, 0, 1, 0);
        run_group(1, 2'b10, 0, 5, 2'b01, 1, 0, 0);
        run_group(2, 2'b11, 0, 0, 2'b10, 0, 1, 0);
        run_group(3, 2'b10, 1, 5, 2'b11, 1, 1, 1);
        run_group(3, 2'b00, 0, 15, 2'b11, 0, 1, 0);

        // R1: unselected sources ignored
        cfg_start_mode = 2'b10;
        @(negedge clk);
        sw_start = 1'b1; cnv_pin = 1'b1; t2_lo_ovf = 1'b1; t2_hi_ovf = 1'b1;
        @(negedge clk);
        sw_start = 1'b0; t2_lo_ovf = 1'b0; t2_hi_ovf = 1'b0;
        repeat (3) @(negedge clk);
        cnv_pin = 1'b0;
        repeat (5) @(negedge clk);
        chk("R1 unselected sources", int'(busy), 0);

        // R2: wrong Timer2 byte ignored
        cfg_start_mode = 2'b11; cfg_t2_split = 1'b1;
        @(negedge clk);
        t2_hi_ovf = 1'b1; @(negedge clk); t2_hi_ovf = 1'b0;
        repeat (4) @(negedge clk);
        chk("R2 split ignores high byte", int'(busy), 0);
        cfg_t2_split = 1'b0;
        @(negedge clk);
        t2_lo_ovf = 1'b1; @(negedge clk); t2_lo_ovf = 1'b0;
        repeat (4) @(negedge clk);
        chk("R2 16-bit ignores low byte", int'(busy), 0);

        // R6: clear collides with completion
        clr_on_last = 1;
        run_group(0, 2'b01, 0, 2, 2'b01, 0, 1, 0);
        clr_on_last = 0;
        run_group(0, 2'b10, 0, 1, 2'b00, 0, 0, 0);
        clr_on_last = 1;
        cfg_start_mode = 2'b00; cfg_track_mode = 2'b10; cfg_repeat = 2'b00;
        n_done = 0; exp_rep = 1;
        fire(0);
        for (int i = 0; i < 100 && busy; i++) @(negedge clk);
        chk("R6 completion beats clear", int'(eoc_flag), 1);
        clr_on_last = 0;
        pulse_clear();

        for (int k = 0; k < 30; k++) begin
            run_group(int'($urandom % 4), 2'($urandom), 1'($urandom), int'($urandom % 16),
                      2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end
endmodule